// File: doc/BRIEF.md
# Mixed-Mode Reseeding Logic BIST Controller

This block sequences scan-based logic self-test for a set of scan chains. A linear-feedback pattern generator (PRPG) supplies every scan-in bit through a fixed XOR spreading network. Each test step loads a pattern by shifting, applies a single capture clock, and sends the captured response out while the next pattern goes in. The responses that come out are compressed in a multiple-input signature register (MISR).

A schedule table, fixed by a parameter, sets the kind of each step, and the kinds may come in any order. A pseudorandom step continues from whatever state the generator holds. A deterministic step first takes a fresh seed bit by bit from a tester or seed memory through a valid/ready handshake. A partial step clocks only the generator for a programmed number of cycles, with scan idle, which produces a new start state without any load. When the schedule reaches its end entry, the last response is unloaded, and the block then raises `done` with the signature ready to read.

Top module: `lbist_reseed_ctrl`

## Requirements
- R1: Each pattern step asserts `scan_en` for exactly CHAIN_LEN clocks and then `capture` for exactly one clock. `scan_en` is low during that clock, and `capture` never lasts two clocks in a row.
- R2: On every shift clock, chain c receives `scan_in[c] = p[c] ^ p[PRPG_W-1-c]`, where p is the current generator state. After that clock the generator becomes `{p[PRPG_W-2:0], ^(p & PRPG_POLY)}`. A pattern therefore depends only on the state at the start of its shift.
- R3: A pseudorandom entry does not reload the generator. Its pattern starts from the state left by the previous step.
- R4: A deterministic entry raises `seed_ready` and accepts exactly PRPG_W bits, one on each clock where `seed_valid` and `seed_ready` are both high. Feedback is off during the load, and the first bit accepted ends up in the generator MSB. The seed replaces the state completely, and shifting starts right after the last bit.
- R5: While a seed loads or a partial step runs, `scan_en` is low. Whenever `scan_en` is low (except on a start clock), the signature does not change.
- R6: A partial entry with count n advances the generator by exactly n steps. A count of 0 leaves it unchanged.
- R7: Schedule entry i occupies `SCHED[10*i+9 : 10*i]`. Bits [9:8] give the kind (00 pseudorandom, 01 deterministic, 10 partial, 11 end) and bits [7:0] give the partial count. Entries run in ascending index order.
- R8: The response of each pattern leaves during the shift of the next one. After the end entry, a final unload of CHAIN_LEN `scan_en` clocks with no capture takes place. `done` then rises and stays high, with the signature steady, until the next start. The generator holds during unload and while idle or done.
- R9: On each clock with `scan_en` high while the chains hold a captured response, the signature s becomes `{s[M-2:0],0} ^ (s[M-1] ? MISR_POLY : 0) ^ scan_out`, with chain c at bit c. Shift clocks of the first pattern after a start leave it unchanged.
- R10: While reset is asserted, `scan_en`, `capture`, `seed_ready` and `done` are low and the signature is zero.
- R11: A start pulse while idle or done clears the signature and restarts at entry 0. The generator keeps its state across runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-clock pulse that begins a test run |
| seed_valid | input | 1 | Seed source presents a bit |
| seed_bit | input | 1 | Serial seed data, MSB first |
| seed_ready | output | 1 | Block is taking seed bits |
| scan_en | output | 1 | Scan shift enable for all chains |
| scan_in | output | N_CHAINS | Scan-in data, one bit per chain |
| capture | output | 1 | Capture strobe, one clock per pattern |
| scan_out | input | N_CHAINS | Scan-out data from the chain tails |
| done | output | 1 | Run finished, signature final |
| signature | output | MISR_W | MISR contents |

## Verification
The properties assume that `start` is pulsed only while the block is idle or done, that `seed_valid` means something only while `seed_ready` is high, and that `scan_out` comes from chains that shift only when `scan_en` is high. The bench keeps to these assumptions. It pulses start only after `done`, and its seed source raises valid only on clocks where it saw ready. It also models the chains itself, shifting on `scan_en` and replacing their contents with a fixed response function on `capture`. The seed source first inserts idle clocks between bits and later sends bits back to back, so the load count is tested under both pacings.

// File: rtl/lbist_pkg.sv
// Shared types for the reseeding BIST controller.
// Assumes schedule entries are ENTRY_W bits: kind in the top two bits, count below.
package lbist_pkg;

    localparam int ENTRY_W = 10;
    localparam int COUNT_W = 8;

    typedef enum logic [1:0] {
        KIND_RAND = 2'b00,
        KIND_SEED = 2'b01,
        KIND_PART = 2'b10,
        KIND_END  = 2'b11
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e            kind;
        logic [COUNT_W-1:0]   count;
    } sched_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEED,
        ST_SHIFT,
        ST_CAPTURE,
        ST_PART,
        ST_UNLOAD,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/lbist_prpg.sv
// Fibonacci LFSR pattern generator with a serial seed load.
// Assumes load and step are never needed together; load wins if both are high.
// During a load, feedback is replaced by the incoming bit, so W loads replace the state.
module lbist_prpg #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   POLY = 16'hD008,
    parameter logic [W-1:0]   INIT = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic         load_bit,
    output logic [W-1:0] state
);

    logic fb;

    // Feedback parity over the tap positions.
    always_comb fb = ^(state & POLY);

    // State register: reset to INIT, shift in a seed bit or the feedback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= INIT;
        end else if (load) begin
            state <= {state[W-2:0], load_bit};
        end else if (step) begin
            state <= {state[W-2:0], fb};
        end
    end

endmodule

// File: rtl/lbist_phase_shift.sv
// Fixed XOR spreading network from generator state to chain inputs.
// Assumes N <= W/2 so each chain pairs two distinct state bits.
module lbist_phase_shift #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic [W-1:0] prpg_state,
    output logic [N-1:0] chain_in
);

    for (genvar c = 0; c < N; c++) begin : g_tap
        // Chain c mixes a low bit with its mirror from the top.
        assign chain_in[c] = prpg_state[c] ^ prpg_state[W-1-c];
    end

endmodule

// File: rtl/lbist_misr.sv
// Multiple-input signature register, Galois form, chain c injected at bit c.
// Assumes N <= W. Clear has priority over enable.
module lbist_misr #(
    parameter int           W    = 16,
    parameter int           N    = 4,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [N-1:0] data,
    output logic [W-1:0] sig
);

    logic [W-1:0] inject;
    logic [W-1:0] fold;

    // Zero-extend the response slice and form the feedback term.
    always_comb begin
        inject         = '0;
        inject[N-1:0]  = data;
        fold           = sig[W-1] ? POLY : '0;
    end

    // Signature register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig <= '0;
        end else if (clr) begin
            sig <= '0;
        end else if (en) begin
            sig <= {sig[W-2:0], 1'b0} ^ fold ^ inject;
        end
    end

endmodule

// File: rtl/lbist_sequencer.sv
// Schedule-driven control FSM for mixed-mode reseeding BIST.
// Reads one schedule entry per FETCH clock, then runs seed load, shift,
// capture, partial or final unload. Assumes start is pulsed only while
// idle or done; start at other times is ignored.
module lbist_sequencer
    import lbist_pkg::*;
#(
    parameter int                          PRPG_W      = 16,
    parameter int                          CHAIN_LEN   = 8,
    parameter int                          SCHED_DEPTH = 10,
    parameter logic [SCHED_DEPTH*ENTRY_W-1:0] SCHED    = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic seed_valid,
    output logic seed_ready,
    output logic scan_en,
    output logic capture,
    output logic done,
    output logic prpg_step,
    output logic prpg_load,
    output logic misr_en,
    output logic misr_clr
);

    localparam int PTR_W   = $clog2(SCHED_DEPTH + 1);
    localparam int IDX_W   = (SCHED_DEPTH > 1) ? $clog2(SCHED_DEPTH) : 1;
    localparam int BIG     = (CHAIN_LEN > PRPG_W) ? CHAIN_LEN : PRPG_W;
    localparam int CNT_MAX = (BIG > 256) ? BIG : 256;
    localparam int CNT_W   = $clog2(CNT_MAX);

    sched_entry_t          tbl [SCHED_DEPTH];
    sched_entry_t          cur;
    seq_state_e            st_q, st_d;
    logic [PTR_W-1:0]      ptr_q, ptr_d;
    logic [IDX_W-1:0]      ptr_idx;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic                  pend_q, pend_d;

    for (genvar i = 0; i < SCHED_DEPTH; i++) begin : g_tbl
        // Unpack entry i from the schedule parameter.
        assign tbl[i] = sched_entry_t'(SCHED[i*ENTRY_W +: ENTRY_W]);
    end

    assign ptr_idx = ptr_q[IDX_W-1:0];

    // Current entry; reading past the table behaves as an end entry.
    always_comb begin
        if (ptr_q < PTR_W'(SCHED_DEPTH)) begin
            cur = tbl[ptr_idx];
        end else begin
            cur = '{kind: KIND_END, count: '0};
        end
    end

    // Next-state and counter logic.
    always_comb begin
        st_d     = st_q;
        ptr_d    = ptr_q;
        cnt_d    = cnt_q;
        pend_d   = pend_q;
        misr_clr = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    st_d     = ST_FETCH;
                    ptr_d    = '0;
                    pend_d   = 1'b0;
                    misr_clr = 1'b1;
                end
            end
            ST_FETCH: begin
                if (cur.kind != KIND_END) begin
                    ptr_d = ptr_q + 1'b1;
                end
                unique case (cur.kind)
                    KIND_RAND: begin
                        st_d  = ST_SHIFT;
                        cnt_d = CNT_W'(CHAIN_LEN - 1);
                    end
                    KIND_SEED: begin
                        st_d  = ST_SEED;
                        cnt_d = CNT_W'(PRPG_W - 1);
                    end
                    KIND_PART: begin
                        if (cur.count != '0) begin
                            st_d  = ST_PART;
                            cnt_d = CNT_W'(cur.count) - 1'b1;
                        end
                    end
                    KIND_END: begin
                        if (pend_q) begin
                            st_d  = ST_UNLOAD;
                            cnt_d = CNT_W'(CHAIN_LEN - 1);
                        end else begin
                            st_d  = ST_DONE;
                        end
                    end
                    default: st_d = ST_IDLE;
                endcase
            end
            ST_SEED: begin
                if (seed_valid) begin
                    if (cnt_q == '0) begin
                        st_d  = ST_SHIFT;
                        cnt_d = CNT_W'(CHAIN_LEN - 1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (cnt_q == '0) begin
                    st_d = ST_CAPTURE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_CAPTURE: begin
                st_d   = ST_FETCH;
                pend_d = 1'b1;
            end
            ST_PART: begin
                if (cnt_q == '0) begin
                    st_d = ST_FETCH;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_UNLOAD: begin
                if (cnt_q == '0) begin
                    st_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ptr_q  <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ptr_q  <= ptr_d;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    // Output decode from the current state.
    always_comb begin
        seed_ready = (st_q == ST_SEED);
        scan_en    = (st_q == ST_SHIFT) || (st_q == ST_UNLOAD);
        capture    = (st_q == ST_CAPTURE);
        done       = (st_q == ST_DONE);
        prpg_step  = (st_q == ST_SHIFT) || (st_q == ST_PART);
        prpg_load  = (st_q == ST_SEED) && seed_valid;
        misr_en    = ((st_q == ST_SHIFT) && pend_q) || (st_q == ST_UNLOAD);
    end

endmodule

// File: rtl/lbist_reseed_ctrl.sv
// Top of the mixed-mode reseeding logic BIST controller.
// Connects the schedule sequencer, pattern generator, spreading network
// and signature register. Assumes scan_out comes from chains that shift
// on scan_en and load the response on capture.
module lbist_reseed_ctrl
    import lbist_pkg::*;
#(
    parameter int                    PRPG_W      = 16,
    parameter logic [PRPG_W-1:0]     PRPG_POLY   = 16'hD008,
    parameter logic [PRPG_W-1:0]     PRPG_INIT   = 16'hACE1,
    parameter int                    N_CHAINS    = 4,
    parameter int                    CHAIN_LEN   = 8,
    parameter int                    MISR_W      = 16,
    parameter logic [MISR_W-1:0]     MISR_POLY   = 16'h1021,
    parameter int                    SCHED_DEPTH = 10,
    parameter logic [SCHED_DEPTH*ENTRY_W-1:0] SCHED = {
        10'h300, 10'h203, 10'h000, 10'h200, 10'h100,
        10'h000, 10'h205, 10'h000, 10'h100, 10'h000
    }
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                seed_valid,
    input  logic                seed_bit,
    output logic                seed_ready,
    output logic                scan_en,
    output logic [N_CHAINS-1:0] scan_in,
    output logic                capture,
    input  logic [N_CHAINS-1:0] scan_out,
    output logic                done,
    output logic [MISR_W-1:0]   signature
);

    logic              prpg_step;
    logic              prpg_load;
    logic              misr_en;
    logic              misr_clr;
    logic [PRPG_W-1:0] prpg_state;

    lbist_sequencer #(
        .PRPG_W      (PRPG_W),
        .CHAIN_LEN   (CHAIN_LEN),
        .SCHED_DEPTH (SCHED_DEPTH),
        .SCHED       (SCHED)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .seed_valid (seed_valid),
        .seed_ready (seed_ready),
        .scan_en    (scan_en),
        .capture    (capture),
        .done       (done),
        .prpg_step  (prpg_step),
        .prpg_load  (prpg_load),
        .misr_en    (misr_en),
        .misr_clr   (misr_clr)
    );

    lbist_prpg #(
        .W    (PRPG_W),
        .POLY (PRPG_POLY),
        .INIT (PRPG_INIT)
    ) u_prpg (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (prpg_step),
        .load     (prpg_load),
        .load_bit (seed_bit),
        .state    (prpg_state)
    );

    lbist_phase_shift #(
        .W (PRPG_W),
        .N (N_CHAINS)
    ) u_ps (
        .prpg_state (prpg_state),
        .chain_in   (scan_in)
    );

    lbist_misr #(
        .W    (MISR_W),
        .N    (N_CHAINS),
        .POLY (MISR_POLY)
    ) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (misr_clr),
        .en    (misr_en),
        .data  (scan_out),
        .sig   (signature)
    );

endmodule

// File: rtl/lbist_reseed_ctrl_chk.sv
// Protocol checker for lbist_reseed_ctrl, attached by bind.
// Assumes start is pulsed only while idle or done.
module lbist_reseed_ctrl_chk #(
    parameter int PRPG_W = 16,
    parameter int MISR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              seed_valid,
    input logic              seed_ready,
    input logic              scan_en,
    input logic              capture,
    input logic              done,
    input logic [MISR_W-1:0] signature
);

    int unsigned acc;

    // Count bits accepted during the current seed load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= 0;
        end else if (seed_ready) begin
            acc <= acc + (seed_valid ? 1 : 0);
        end else begin
            acc <= 0;
        end
    end

    assert_capture_no_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !scan_en);

    assert_capture_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);

    assert_seed_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ready |-> (!scan_en && !capture));

    assert_sig_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !start) |=> $stable(signature));

    assert_seed_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ready |-> (acc < PRPG_W));

    assert_seed_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seed_ready) |-> (acc == PRPG_W));

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_en && !seed_ready && !capture));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

bind lbist_reseed_ctrl lbist_reseed_ctrl_chk #(
    .PRPG_W (PRPG_W),
    .MISR_W (MISR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .seed_valid (seed_valid),
    .seed_ready (seed_ready),
    .scan_en    (scan_en),
    .capture    (capture),
    .done       (done),
    .signature  (signature)
);

// File: tb/lbist_reseed_ctrl_bench.sv
`timescale 1ns/1ps
module lbist_reseed_ctrl_bench;

    localparam int W     = 16;
    localparam int N     = 4;
    localparam int L     = 8;
    localparam int M     = 16;
    localparam int DEPTH = 10;
    localparam logic [W-1:0] POLY  = 16'hD008;
    localparam logic [W-1:0] INIT  = 16'hACE1;
    localparam logic [M-1:0] MPOLY = 16'h1021;
    // e0 rand, e1 seed, e2 rand, e3 part 5, e4 rand, e5 seed, e6 part 0, e7 rand, e8 part 3, e9 end
    localparam logic [DEPTH*10-1:0] SCHED = {
        10'h300, 10'h203, 10'h000, 10'h200, 10'h100,
        10'h000, 10'h205, 10'h000, 10'h100, 10'h000
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic         seed_valid;
    logic         seed_bit;
    logic         seed_ready;
    logic         scan_en;
    logic [N-1:0] scan_in;
    logic         capture;
    logic [N-1:0] scan_out;
    logic         done;
    logic [M-1:0] signature;

    always #2 clk = ~clk;

    lbist_reseed_ctrl #(
        .PRPG_W(W), .PRPG_POLY(POLY), .PRPG_INIT(INIT), .N_CHAINS(N),
        .CHAIN_LEN(L), .MISR_W(M), .MISR_POLY(MPOLY),
        .SCHED_DEPTH(DEPTH), .SCHED(SCHED)
    ) u_lbist_reseed_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_valid(seed_valid),
        .seed_bit(seed_bit), .seed_ready(seed_ready), .scan_en(scan_en),
        .scan_in(scan_in), .capture(capture), .scan_out(scan_out),
        .done(done), .signature(signature)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference functions written from the requirements.
    function automatic logic [W-1:0] seed_of(input int k);
        case (k)
            0:       return 16'h1234;
            1:       return 16'hBEEF;
            2:       return 16'h0F0F;
            default: return 16'h8001;
        endcase
    endfunction

    function automatic logic [W-1:0] prpg_next(input logic [W-1:0] s);
        return {s[W-2:0], ^(s & POLY)};
    endfunction

    function automatic logic [N-1:0] spread(input logic [W-1:0] s);
        logic [N-1:0] b;
        for (int c = 0; c < N; c++) b[c] = s[c] ^ s[W-1-c];
        return b;
    endfunction

    function automatic logic [L-1:0] respond(input logic [L-1:0] v);
        return ~{v[L-2:0], v[L-1]};
    endfunction

    function automatic logic [M-1:0] misr_next(input logic [M-1:0] s, input logic [N-1:0] b);
        logic [M-1:0] inj;
        inj = '0;
        inj[N-1:0] = b;
        return {s[M-2:0], 1'b0} ^ (s[M-1] ? MPOLY : '0) ^ inj;
    endfunction

    // Scan chain model outside the block.
    logic [L-1:0] chain [N];
    always @(posedge clk) begin
        for (int c = 0; c < N; c++) begin
            if (scan_en) chain[c] <= {chain[c][L-2:0], scan_in[c]};
            else if (capture) chain[c] <= respond(chain[c]);
        end
    end
    always_comb begin
        for (int c = 0; c < N; c++) scan_out[c] = chain[c][L-1];
    end

    // Seed source: gaps between bits for the first two seeds, full rate after.
    int   seed_sel = 0;
    int   seed_idx = 0;
    logic gap = 1'b0;
    always @(negedge clk) begin
        logic [W-1:0] sv;
        sv = seed_of(seed_sel);
        gap        <= ~gap;
        seed_valid <= rst_n && seed_ready && (gap || seed_sel >= 2);
        seed_bit   <= sv[W-1-seed_idx];
    end
    always @(posedge clk) begin
        if (rst_n && seed_ready && seed_valid) begin
            if (seed_idx == W-1) begin
                seed_idx <= 0;
                seed_sel <= seed_sel + 1;
            end else begin
                seed_idx <= seed_idx + 1;
            end
        end
    end

    // Scoreboard state.
    logic [N*L-1:0] exp_q [$];
    string          tag_q [$];
    logic [W-1:0]   model_s;
    int             model_seed = 0;
    logic [M-1:0]   exp_sig;

    // Driver side: compute expected patterns and signature for one run.
    task automatic plan_run(input string pre);
        logic [L-1:0] ch [N];
        logic [M-1:0] m;
        bit           after_part;
        bit           first;
        m = '0;
        after_part = 1'b0;
        first = 1'b1;
        for (int c = 0; c < N; c++) ch[c] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [9:0]   e;
            logic [N*L-1:0] pat;
            string        tag;
            e = SCHED[i*10 +: 10];
            if (e[9:8] == 2'b11) break;
            if (e[9:8] == 2'b10) begin
                for (int k = 0; k < int'(e[7:0]); k++) model_s = prpg_next(model_s);
                after_part = 1'b1;
                continue;
            end
            if (e[9:8] == 2'b01) begin
                model_s = seed_of(model_seed);
                model_seed++;
                tag = "R4 R2 seeded pattern";
            end else if (after_part) begin
                tag = "R6 R2 pattern after partial";
            end else begin
                tag = "R3 R2 continued pattern";
            end
            if (first) tag = {pre, tag};
            first = 1'b0;
            after_part = 1'b0;
            for (int k = 0; k < L; k++) begin
                logic [N-1:0] b;
                b = spread(model_s);
                for (int c = 0; c < N; c++) ch[c] = {ch[c][L-2:0], b[c]};
                model_s = prpg_next(model_s);
            end
            for (int c = 0; c < N; c++) pat[c*L +: L] = ch[c];
            exp_q.push_back(pat);
            tag_q.push_back({"R7 ", tag});
            for (int c = 0; c < N; c++) ch[c] = respond(ch[c]);
            for (int k = 0; k < L; k++) begin
                logic [N-1:0] o;
                for (int c = 0; c < N; c++) o[c] = ch[c][L-1-k];
                m = misr_next(m, o);
            end
        end
        exp_sig = m;
    endtask

    // Monitor side: compare at each capture and watch protocol at the ports.
    int           shift_cnt = 0;
    logic         prev_scan_en = 1'b1;
    logic         prev_start = 1'b1;
    logic         prev_done = 1'b0;
    logic [M-1:0] prev_sig = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (seed_ready) check(!scan_en, "R5 scan_en during seed load", 64'(scan_en), 64'd0);
            if (!prev_scan_en && !prev_start)
                check(signature === prev_sig, "R5 signature held while scan idle", 64'(signature), 64'(prev_sig));
            if (scan_en) shift_cnt++;
            if (capture) begin
                logic [N*L-1:0] got;
                check(shift_cnt == L, "R1 shift clocks before capture", 64'(shift_cnt), 64'(L));
                shift_cnt = 0;
                for (int c = 0; c < N; c++) got[c*L +: L] = chain[c];
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected capture", 64'(got), 64'd0);
                end else begin
                    logic [N*L-1:0] want;
                    string          t;
                    want = exp_q.pop_front();
                    t    = tag_q.pop_front();
                    check(got === want, t, 64'(got), 64'(want));
                end
            end
            if (done && !prev_done) begin
                check(shift_cnt == L, "R8 final unload clocks", 64'(shift_cnt), 64'(L));
                shift_cnt = 0;
            end
        end
        prev_scan_en = scan_en;
        prev_start   = start;
        prev_done    = done;
        prev_sig     = signature;
    end

    initial begin
        bit hung;
        hung    = 1'b0;
        rst_n   = 1'b0;
        start   = 1'b0;
        model_s = INIT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!scan_en && !capture && !seed_ready && !done, "R10 control outputs in reset",
              64'({scan_en, capture, seed_ready, done}), 64'd0);
        check(signature === '0, "R10 signature in reset", 64'(signature), 64'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        for (int r = 0; r < 2 && !hung; r++) begin
            plan_run(r == 0 ? "" : "R11 ");
            #1 start = 1'b1;
            @(posedge clk);
            #1 start = 1'b0;
            for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
            if (!done) begin
                check(1'b0, "R8 watchdog: done never rose", 64'd0, 64'd1);
                hung = 1'b1;
            end else begin
                @(negedge clk);
                check(signature === exp_sig, r == 0 ? "R9 final signature" : "R11 R9 signature after restart",
                      64'(signature), 64'(exp_sig));
                check(exp_q.size() == 0, "R7 all scheduled patterns captured", 64'(exp_q.size()), 64'd0);
                repeat (3) @(negedge clk);
                check(done === 1'b1, "R8 done held until start", 64'(done), 64'd1);
                check(signature === exp_sig, "R8 signature steady while done", 64'(signature), 64'(exp_sig));
                @(posedge clk);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule